// File: doc/BRIEF.md
# SAR Converter Serial Readout Port (Chip-Select Mode with Busy Indicator)

This block models the digital side of a successive-approximation converter that is read over a four-wire serial link in chip-select mode. The host starts a conversion with a rising edge on the convert line while the select line is high. The port then holds its serial output in high impedance for a fixed conversion time. When the time is up, the port drives the output low if the host has lowered the select line, and the host can treat that edge as an interrupt. The host then clocks the captured sample out, most significant bit first, one bit per falling serial-clock edge.

All inputs are sampled in a single system-clock domain through a synchroniser chain. Serial-clock and convert-line edges are found by comparing the last two synchronised values. The sample word comes in parallel from a stub data source and is frozen into a shift register when the conversion ends. The output driver's enable is a separate port, so that high impedance is visible without a tri-state net.

Top module: `adc_rd_port`

## Requirements
- R1: After reset, with the convert and select lines both low, the port drives its output low (`sdo_oe_o`=1, `sdo_o`=0).
- R2: While idle, with the convert line low and the select line high, the output is in high impedance (`sdo_oe_o`=0).
- R3: A rising convert edge while select is high starts a conversion. The output stays disabled for exactly `CONV_CYCLES` system clocks after the edge is recognised, and the edge is recognised `SYNC_STAGES`+1 clocks after it reaches the pin.
- R4: At the end of the conversion, if select is low, the output is enabled and driven low (busy/ready indication).
- R5: Each falling serial-clock edge during readout presents the next sample bit on `sdo_o`, from bit 17 down to bit 0.
- R6: The 19th falling serial-clock edge of a readout returns the output to high impedance. It stays there until the convert line goes low.
- R7: A rising edge on select during readout returns the output to high impedance at once and ends the readout.
- R8: The convert line going low during a conversion or a readout aborts the cycle, and the port returns to idle.
- R9: If select is still high at the end of the conversion, no busy level is driven. The output stays in high impedance for the whole readout.
- R10: The sample is captured when the conversion ends, and later changes on `sample_i` do not alter the bits shifted out.
- R11: A rising convert edge while select is low starts no conversion. The output stays in high impedance while convert is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_i | input | 1 | Convert line; rising edge samples, level frames the cycle |
| sel_i | input | 1 | Serial data-in line used as the chip select |
| sclk_i | input | 1 | Serial clock from the host |
| sample_i | input | 18 | Parallel sample word from the data source |
| sdo_o | output | 1 | Serial data / busy level |
| sdo_oe_o | output | 1 | Output driver enable (0 = high impedance) |

## Verification
On every cycle the assertions check several rules: a dropped convert line returns the controller to idle, a conversion only starts when select was high, the first readout cycle of a busy-indicating frame drives low, the conversion counter and bit counter stay in range, and the shift register holds still between shifts. Only the bench scenarios can show the exact length of the conversion window at the pins, the MSB-first bit order for varied words, the frame end on the 19th edge, early termination by select, and the freezing of the sample against later input changes.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2,
        ST_DONE = 2'd3
    } rd_state_e;

    // Order of the synchronised control lines inside the line vector
    localparam int LN_SCLK = 0;
    localparam int LN_SEL  = 1;
    localparam int LN_CONV = 2;
    localparam int LN_NUM  = 3;

    typedef struct packed {
        logic conv;
        logic sel;
        logic sclk;
    } line_s;

    typedef struct packed {
        logic conv_rise;
        logic sel_rise;
        logic sclk_fall;
    } edge_s;

    function automatic int frame_edges(input int width);
        return width + 1;
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_o <= '0;
        else     prev_o <= stage_q[STAGES-1];
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || done_o) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

    // R3
    conv_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R3
    conv_cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             shift_i,
    output logic             bit_o
);

    logic [WIDTH-1:0] word_q;
    logic             out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            out_q  <= 1'b0;
        end else if (load_i) begin
            word_q <= data_i;
            out_q  <= 1'b0;
        end else if (shift_i) begin
            out_q  <= word_q[WIDTH-1];
            word_q <= {word_q[WIDTH-2:0], 1'b0};
        end
    end

    assign bit_o = out_q;

    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !shift_i) |=> $stable(word_q));

    // R4
    load_clears_out_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !out_q);

endmodule

// File: rtl/adc_rd_port.sv
module adc_rd_port
    import adc_rd_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int CONV_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_i,
    input  logic              sel_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam int FRAME = frame_edges(DATA_W);
    localparam int BW    = $clog2(FRAME + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W);

    line_s            raw, lvl, lvl_p;
    edge_s            edg;
    logic [LN_NUM-1:0] lvl_v, prev_v;

    rd_state_e        state_q, state_d;
    logic [BW-1:0]    bits_q, bits_d;
    logic             drive_q, drive_d;
    logic             tmr_done, load, shift, data_bit;

    assign raw.conv = conv_i;
    assign raw.sel  = sel_i;
    assign raw.sclk = sclk_i;

    adc_rd_sync #(.WIDTH(LN_NUM), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    (raw),
        .q_o    (lvl_v),
        .prev_o (prev_v)
    );

    assign lvl   = line_s'(lvl_v);
    assign lvl_p = line_s'(prev_v);

    assign edg.conv_rise = lvl.conv & ~lvl_p.conv;
    assign edg.sel_rise  = lvl.sel  & ~lvl_p.sel;
    assign edg.sclk_fall = ~lvl.sclk & lvl_p.sclk;

    adc_rd_timer #(.LIMIT(CONV_CYCLES)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (state_q == ST_CONV),
        .done_o (tmr_done)
    );

    adc_rd_shifter #(.WIDTH(DATA_W)) i_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .data_i  (sample_i),
        .shift_i (shift),
        .bit_o   (data_bit)
    );

    always_comb begin
        state_d = state_q;
        bits_d  = bits_q;
        drive_d = drive_q;
        load    = 1'b0;
        shift   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (edg.conv_rise && lvl.sel) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (!lvl.conv) begin
                    state_d = ST_IDLE;
                end else if (tmr_done) begin
                    state_d = ST_READ;
                    load    = 1'b1;
                    bits_d  = '0;
                    drive_d = !lvl.sel;
                end
            end
            ST_READ: begin
                if (!lvl.conv) begin
                    state_d = ST_IDLE;
                end else if (edg.sel_rise) begin
                    state_d = ST_DONE;
                end else if (edg.sclk_fall) begin
                    if (bits_q == LAST_BIT) begin
                        state_d = ST_DONE;
                    end else begin
                        shift  = 1'b1;
                        bits_d = bits_q + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (!lvl.conv) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            drive_q <= 1'b0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            drive_q <= drive_d;
        end
    end

    always_comb begin
        sdo_oe_o = 1'b0;
        sdo_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: sdo_oe_o = !lvl.conv && !lvl.sel;
            ST_READ: begin
                sdo_oe_o = drive_q;
                sdo_o    = drive_q && data_bit;
            end
            default: begin
                sdo_oe_o = 1'b0;
                sdo_o    = 1'b0;
            end
        endcase
    end

    // R8
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lvl.conv |=> (state_q == ST_IDLE));

    // R11
    start_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && state_d == ST_CONV) |-> lvl.sel);

    // R4
    busy_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && state_d == ST_READ && !lvl.sel)
            |=> (sdo_oe_o && !sdo_o));

    // R6
    bit_count_range_chk: assert property (@(posedge clk) disable iff (rst)
        bits_q <= LAST_BIT);

    // R9
    no_busy_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ && !drive_q) |-> !sdo_oe_o);

endmodule

// File: tb/test_adc_rd_port.sv
module test_adc_rd_port;

    localparam int DW = 18;
    localparam int CC = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv = 1'b0;
    logic          sel = 1'b0;
    logic          sclk = 1'b0;
    logic [DW-1:0] sample = '0;
    logic          sdo, sdo_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_rd_port #(.DATA_W(DW), .CONV_CYCLES(CC), .SYNC_STAGES(2)) i_adc_rd_port (
        .clk      (clk),
        .rst      (rst),
        .conv_i   (conv),
        .sel_i    (sel),
        .sclk_i   (sclk),
        .sample_i (sample),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe)
    );

    // {busy expected (select lowered during conversion), sample word}
    localparam logic [DW:0] VEC [6] = '{
        {1'b1, 18'h2A5A5},
        {1'b1, 18'h3FFFF},
        {1'b1, 18'h00001},
        {1'b1, 18'h20000},
        {1'b0, 18'h15A3C},
        {1'b1, 18'h0F0F0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse();
        sclk = 1'b1;
        wait_n(4);
        sclk = 1'b0;
        wait_n(4);
    endtask

    // Start a conversion; optionally drop select before the end of it.
    task automatic start_conv(input logic drop_sel);
        sel  = 1'b1;
        conv = 1'b0;
        wait_n(4);
        conv = 1'b1;
        wait_n(4);
        if (drop_sel) sel = 1'b0;
        wait_n(CC + 4);
    endtask

    task automatic end_cycle();
        conv = 1'b0;
        sel  = 1'b1;
        sclk = 1'b0;
        wait_n(4);
    endtask

    task automatic run_read(input logic [DW-1:0] smp, input logic busy);
        sample = smp;
        start_conv(busy);
        chk(busy ? "R4 busy enable" : "R9 no busy", 32'(sdo_oe), 32'(busy));
        chk("R4 busy level", 32'(sdo), 32'h0);
        sample = ~smp;   // R10: must not reach the shifted word
        for (int i = 0; i < DW; i++) begin
            sclk_pulse();
            chk(busy ? "R5 enable" : "R9 enable", 32'(sdo_oe), 32'(busy));
            chk("R5 R10 data bit", 32'(sdo), busy ? 32'(smp[DW-1-i]) : 32'h0);
        end
        sclk_pulse();
        chk("R6 hiz after edge 19", 32'(sdo_oe), 32'h0);
        sclk_pulse();
        chk("R6 hiz held", 32'(sdo_oe), 32'h0);
        end_cycle();
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(4);
        // R1 reset state with both lines low
        chk("R1 oe after reset", 32'(sdo_oe), 32'h1);
        chk("R1 sdo after reset", 32'(sdo), 32'h0);

        // R2 idle with select high
        sel = 1'b1;
        wait_n(4);
        chk("R2 idle hiz", 32'(sdo_oe), 32'h0);

        // Vector table walk
        foreach (VEC[v]) begin
            run_read(VEC[v][DW-1:0], VEC[v][DW]);
        end

        // R3 exact conversion window
        sample = 18'h3FFFF;
        sel  = 1'b1;
        conv = 1'b0;
        wait_n(4);
        conv = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        sel = 1'b0;
        repeat (CC - 2) @(posedge clk);   // C+1 posedges since convert rose
        @(negedge clk);
        chk("R3 still converting", 32'(sdo_oe), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 last conv cycle", 32'(sdo_oe), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 R4 ready at window end", 32'(sdo_oe), 32'h1);

        // R7 select rising mid readout
        repeat (5) sclk_pulse();
        chk("R7 before select rise", 32'(sdo), 32'h1);
        sel = 1'b1;
        wait_n(4);
        chk("R7 hiz on select rise", 32'(sdo_oe), 32'h0);
        sel = 1'b0;
        wait_n(4);
        sclk_pulse();
        chk("R7 stays hiz", 32'(sdo_oe), 32'h0);
        end_cycle();

        // R8 abort during readout
        sample = 18'h3FFFF;
        start_conv(1'b1);
        sclk_pulse();
        chk("R8 reading ones", 32'(sdo), 32'h1);
        conv = 1'b0;
        wait_n(4);
        chk("R8 idle drives low", 32'(sdo_oe), 32'h1);
        sclk_pulse();
        chk("R8 no data after abort", 32'(sdo), 32'h0);
        end_cycle();

        // R8 abort during conversion
        sel  = 1'b1;
        wait_n(4);
        conv = 1'b1;
        wait_n(6);
        conv = 1'b0;
        wait_n(CC + 6);
        chk("R8 conv abort hiz idle", 32'(sdo_oe), 32'h0);
        sel = 1'b0;
        wait_n(4);
        chk("R8 idle after conv abort", 32'(sdo_oe), 32'h1);

        // R11 convert edge with select low
        conv = 1'b1;
        wait_n(CC + 8);
        chk("R11 no conversion", 32'(sdo_oe), 32'h0);
        sclk_pulse();
        chk("R11 still hiz", 32'(sdo_oe), 32'h0);
        conv = 1'b0;
        wait_n(4);
        chk("R11 back low", 32'(sdo_oe), 32'h1);

        // R1 reset in the middle of a readout
        sample = 18'h3FFFF;
        start_conv(1'b1);
        sclk_pulse();
        conv = 1'b0;
        sel  = 1'b0;
        rst  = 1'b1;
        wait_n(3);
        rst  = 1'b0;
        wait_n(4);
        chk("R1 oe after mid reset", 32'(sdo_oe), 32'h1);
        chk("R1 sdo after mid reset", 32'(sdo), 32'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule